// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-bit storage register with four clocked behaviours. It can keep its value, move every bit one place toward the high end, move every bit one place toward the low end, or take a whole byte at once. Each change happens on the rising clock edge. A single set of eight bidirectional lines carries both the byte that is loaded and the register's contents when they are read out. The register drives those lines only when two active-low enables are both low and no load is selected. In every other case it leaves the lines floating for another driver.

Each shift direction has its own serial input. The lowest and highest register bits also appear on two dedicated outputs that are always driven. Several of these registers can therefore be chained in either direction. An active-low reset clears the register at once, without waiting for a clock edge.

Top module: `ushift_bidir`

## Requirements
- R1: While `rst_n` is low the register is zero, and it clears immediately on the falling edge of `rst_n` without a clock edge. `end_lo_o` and `end_hi_o` read 0 for as long as `rst_n` is low.
- R2: With `mode_i` = 2'b00 (hold), a clock edge leaves the register unchanged.
- R3: With `mode_i` = 2'b01, a clock edge moves bit n into bit n+1 and loads `ser_up_i` into bit 0.
- R4: With `mode_i` = 2'b10, a clock edge moves bit n+1 into bit n and loads `ser_down_i` into bit 7.
- R5: With `mode_i` = 2'b11, a clock edge copies the value on `pbus` into the register, with `pbus[i]` going to bit i.
- R6: When `oe_a_n` and `oe_b_n` are both 0 and `mode_i` is not 2'b11, `pbus` carries the register contents.
- R7: When `oe_a_n` or `oe_b_n` is 1, `pbus` is high-impedance.
- R8: When `mode_i` = 2'b11, `pbus` is high-impedance whatever the enables are.
- R9: `end_lo_o` always equals register bit 0 and `end_hi_o` always equals bit 7, whatever the enables are.
- R10: Any chain of mixed up and down shifts produces the bit order that the per-step rules of R3 and R4 give.
- R11: A low `rst_n` overrides every mode. Clock edges that arrive while reset is held, including edges in load mode, leave the register at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_up_i | input | 1 | Serial bit entering bit 0 on an up shift |
| ser_down_i | input | 1 | Serial bit entering bit 7 on a down shift |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| pbus | inout | 8 | Shared parallel load input and tri-state read-out |
| end_lo_o | output | 1 | Register bit 0, always driven |
| end_hi_o | output | 1 | Register bit 7, always driven |

## Verification
The hardest state to observe from the ports is a floating `pbus`. On its own it cannot be told apart from the register driving a value. The bench places pull-ups on every line and first loads all zeros. Each enable combination and the load mode are then applied between clock edges. A released bus reads all ones, while a bus that is wrongly driven reads zeros. The mixed-shift chains are generated from an arithmetic pattern. Their effects are read back over `pbus` in hold mode, which covers the bit order in both directions without a dedicated read port.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
  import ushift_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_raw,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output mode_e      mode,
  output logic       drive_en
);
  logic enables_on;

  assign mode       = mode_e'(mode_raw);
  assign enables_on = ~(oe_a_n | oe_b_n);
  assign drive_en   = enables_on & (mode != MODE_LOAD);

  // R8: a load must never see the block fighting the external driver
  assert_release_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_raw == 2'b11) |-> !drive_en);
  // R7: any raised enable releases the bus
  assert_release_on_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !drive_en);
endmodule

// File: rtl/ushift_core.sv
module ushift_core
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             ser_up,
  input  logic             ser_down,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] state
);
  localparam int TOP = WIDTH - 1;

  function automatic logic [WIDTH-1:0] step_up(logic [WIDTH-1:0] v, logic sin);
    return {v[TOP-1:0], sin};
  endfunction

  function automatic logic [WIDTH-1:0] step_down(logic [WIDTH-1:0] v, logic sin);
    return {sin, v[TOP:1]};
  endfunction

  logic [WIDTH-1:0] next_state;

  always_comb begin
    unique case (mode)
      MODE_UP:   next_state = step_up(state, ser_up);
      MODE_DOWN: next_state = step_down(state, ser_down);
      MODE_LOAD: next_state = load_data;
      default:   next_state = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= next_state;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(state));
  assert_shift_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UP) |=> (state[0] == $past(ser_up)) && (state[TOP:1] == $past(state[TOP-1:0])));
  assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DOWN) |=> (state[TOP] == $past(ser_down)) && (state[TOP-1:0] == $past(state[TOP:1])));
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> (state == $past(load_data)));
endmodule

// File: rtl/ushift_bidir.sv
module ushift_bidir
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             ser_up_i,
  input  logic             ser_down_i,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  inout  wire  [WIDTH-1:0] pbus,
  output logic             end_lo_o,
  output logic             end_hi_o
);
  mode_e            mode;
  logic             drive_en;
  logic [WIDTH-1:0] state;

  ushift_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_raw (mode_i),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .mode     (mode),
    .drive_en (drive_en)
  );

  ushift_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ser_up    (ser_up_i),
    .ser_down  (ser_down_i),
    .load_data (pbus),
    .state     (state)
  );

  assign pbus     = drive_en ? state : {WIDTH{1'bz}};
  assign end_lo_o = state[0];
  assign end_hi_o = state[WIDTH-1];

  // R1: end outputs sit at zero one edge into a held reset
  assert_ends_in_reset_R1: assert property (@(posedge clk)
    (!rst_n && !$past(rst_n)) |-> (!end_lo_o && !end_hi_o));
endmodule

// File: tb/ushift_bidir_test.sv
`timescale 1ns/1ps
module ushift_bidir_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       s_up = 1'b0, s_dn = 1'b0;
  logic       oe_a = 1'b0, oe_b = 1'b0;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_val = 8'h00;
  wire  [7:0] pbus;
  logic       end_lo, end_hi;
  int checks = 0, failures = 0;
  logic [7:0] model = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_pull
    pullup (pbus[i]);
  end
  assign pbus = tb_drv ? tb_val : 8'hzz;

  ushift_bidir uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ser_up_i(s_up), .ser_down_i(s_dn),
    .oe_a_n(oe_a), .oe_b_n(oe_b), .pbus(pbus), .end_lo_o(end_lo), .end_hi_o(end_hi)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // read register over the bus in hold mode, enables low
  task automatic read_back(string req, logic [7:0] exp);
    @(negedge clk);
    mode = 2'b00; oe_a = 1'b0; oe_b = 1'b0; tb_drv = 1'b0;
    #1 chk(req, pbus, exp);
    chk({req, " ends"}, {6'd0, end_hi, end_lo}, {6'd0, exp[7], exp[0]});
  endtask

  task automatic clock_op(logic [1:0] m, logic su, logic sd, logic [7:0] d);
    @(negedge clk);
    mode = m; s_up = su; s_dn = sd;
    tb_drv = (m == 2'b11); tb_val = d;
    oe_a = (m == 2'b11); oe_b = 1'b0;
    @(posedge clk); #1;
    tb_drv = 1'b0;
    if (rst_n) begin
      case (m)
        2'b01: begin
          for (int k = 7; k > 0; k--) model[k] = model[k-1];
          model[0] = su;
        end
        2'b10: begin
          for (int k = 0; k < 7; k++) model[k] = model[k+1];
          model[7] = sd;
        end
        2'b11: model = d;
        default: ;
      endcase
    end
  endtask

  task automatic t_reset;
    read_back("R1 reset value", 8'h00);
    @(negedge clk); rst_n = 1'b1;
    clock_op(2'b11, 0, 0, 8'hC3);
    read_back("R5 preload", 8'hC3);
    #2 rst_n = 1'b0; model = 8'h00;
    #1 chk("R1 async clear ends", {6'd0, end_hi, end_lo}, 8'h00);
    clock_op(2'b11, 0, 0, 8'hFF);
    clock_op(2'b01, 1, 1, 8'h00);
    read_back("R11 reset overrides load/shift", 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_load_hold;
    clock_op(2'b11, 0, 0, 8'hA5);
    read_back("R5 load A5", 8'hA5);
    for (int k = 0; k < 4; k++) clock_op(2'b00, 1, 1, 8'h00);
    read_back("R2 hold", 8'hA5);
    clock_op(2'b11, 0, 0, 8'h5A);
    read_back("R5 load 5A", 8'h5A);
  endtask

  task automatic t_shifts;
    clock_op(2'b11, 0, 0, 8'h01);
    for (int k = 0; k < 3; k++) clock_op(2'b01, k[0], 0, 8'h00);
    read_back("R3 up shift", model);
    chk("R3 expected value", model, 8'h0A);
    clock_op(2'b11, 0, 0, 8'h80);
    for (int k = 0; k < 3; k++) clock_op(2'b10, 0, ~k[0], 8'h00);
    read_back("R4 down shift", model);
    chk("R4 expected value", model, 8'hB0);
  endtask

  task automatic t_mixed;
    clock_op(2'b11, 0, 0, 8'h96);
    for (int k = 0; k < 24; k++) begin
      logic [1:0] m;
      m = ((k * 5 + k / 3) % 3 == 0) ? 2'b10 : 2'b01;
      clock_op(m, (k % 4) == 1, (k % 3) == 2, 8'h00);
      if (k % 6 == 5) read_back("R10 mixed chain", model);
    end
  endtask

  task automatic t_bus;
    clock_op(2'b11, 0, 0, 8'h00);
    read_back("R6 drives zeros", 8'h00);
    @(negedge clk); mode = 2'b00; oe_a = 1'b1; oe_b = 1'b0;
    #1 chk("R7 oe_a high releases", pbus, 8'hFF);
    oe_a = 1'b0; oe_b = 1'b1;
    #1 chk("R7 oe_b high releases", pbus, 8'hFF);
    oe_b = 1'b0; mode = 2'b11;
    #1 chk("R8 load mode releases", pbus, 8'hFF);
    mode = 2'b00;
    #1 chk("R6 enabled again", pbus, 8'h00);
    clock_op(2'b11, 0, 0, 8'h81);
    @(negedge clk); mode = 2'b00; oe_a = 1'b1; oe_b = 1'b1;
    #1 chk("R9 ends while bus off", {6'd0, end_hi, end_lo}, 8'h03);
    chk("R7 both high releases", pbus, 8'hFF);
    read_back("R6 drives register", 8'h81);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_load_hold();
    t_shifts();
    t_mixed();
    t_bus();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule